// File: doc/BRIEF.md
# Open-Page DRAM Read Sequencer

This block sits between a cache-block read port and the command pins of one DRAM channel built from a single rank of eight byte-wide devices. Each request carries a physical byte address and a per-request mapping select. The block splits the address into bank, row and column. It compares the row against the row it remembers as open in that bank. It then issues the shortest legal command sequence, which is READs only, ACTIVATE then READs, or PRECHARGE, ACTIVATE then READs.

The eight READs fetch eight consecutive columns, starting at the column where the cache block begins. The 64-bit words that come back on the data pins are passed out as eight beats, and the eighth beat is flagged as last. Rows stay open after a request, so a later request to the same row of the same bank costs only the READ burst. Two address layouts are supported. The row-interleaved layout keeps a whole row's columns in one bank. The line-interleaved layout places the bank bits just above the cache-block offset, so neighbouring blocks spread across banks.

Top module: `dram_open_row_seq`

## Requirements
- R1: After reset, req_ready is 1, no command is issued, no beat is valid, and all eight banks count as closed, so the first request to any bank issues ACTIVATE without PRECHARGE.
- R2: With req_line_mode = 0, the address reads from bit 30 down as row[13:0] at bits 30:17, bank[2:0] at bits 16:14, column[10:0] at bits 13:3, and byte lane at bits 2:0.
- R3: With req_line_mode = 1, row is at bits 30:17, the upper eight column bits are at 16:9, bank at 8:6, the lower three column bits at 5:3, and the byte lane at 2:0.
- R4: A request to a bank with no open row issues ACTIVATE with the request's bank and row, then the READ burst, and no PRECHARGE.
- R5: A request to a bank whose open row differs issues PRECHARGE to that bank, then ACTIVATE, then the READ burst.
- R6: A request whose row equals the open row of its bank issues only the READ burst. Every READ targets the row currently open in its bank.
- R7: ACTIVATE follows PRECHARGE after exactly TRP cycles, and the first READ follows ACTIVATE after exactly TRCD cycles. The eight READs occupy consecutive cycles with columns base+0 to base+7, where base is the request column with its lower three bits cleared.
- R8: Each READ yields one beat TCL cycles later. beat_valid is high in that cycle, beat_data equals dq_in, and beat_last is high only on the eighth beat.
- R9: req_ready falls in the cycle after acceptance and rises again in the cycle after beat_last. While req_ready is high, no command or beat is issued.
- R10: cmd is one-hot or zero, with bit 0 = PRECHARGE, bit 1 = ACTIVATE and bit 2 = READ. Each command lasts one cycle, and cmd_bank, cmd_row and cmd_col belong to it.
- R11: Open rows are kept per bank. A request to one bank never closes or changes another bank's row, and ACTIVATE never reaches a bank that already has an open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_addr | input | 31 | Physical byte address |
| req_line_mode | input | 1 | 0 = row-interleaved layout, 1 = line-interleaved layout |
| cmd | output | 3 | One-hot command: bit 0 precharge, bit 1 activate, bit 2 read |
| cmd_bank | output | 3 | Bank of the command |
| cmd_row | output | 14 | Row of the command |
| cmd_col | output | 11 | Column of a read command |
| dq_in | input | 64 | Data returned by the eight devices |
| beat_valid | output | 1 | A data beat is on beat_data |
| beat_data | output | 64 | Returned block word |
| beat_last | output | 1 | Eighth beat of the block |

## Verification
The bench builds the block with TRP = 2, TRCD = 1 and TCL = 3. With TRCD = 1, ACTIVATE is followed directly by READ with no countdown state, while TRP = 2 passes once through the countdown. With TCL = 3, shorter than the burst, beats start to return while READs are still being issued, so the overlap of issue and return is exercised. A device model tracks open rows from the command pins alone, and expected data comes from an independent decode of each address. A wrong field split, a missed row hit or a mistimed gap therefore shows up as a data or ordering mismatch.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_PRE   = 3'd1,
        SQ_ACT   = 3'd2,
        SQ_GAP   = 3'd3,
        SQ_READ  = 3'd4,
        SQ_DRAIN = 3'd5
    } sq_state_e;

    localparam int CMD_W    = 3;
    localparam int CMD_PRE  = 0;
    localparam int CMD_ACT  = 1;
    localparam int CMD_READ = 2;
endpackage

// File: rtl/rbs_addr_map.sv
module rbs_addr_map #(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    parameter int COL_W  = 11,
    parameter int BYTE_W = 3,
    parameter int BEAT_W = 3,
    parameter int ADDR_W = ROW_W + BANK_W + COL_W + BYTE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              line_mode,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col_base
);
    localparam int HI_W    = COL_W - BEAT_W;
    localparam int ROW_LSB = BYTE_W + COL_W + BANK_W;
    localparam int BLK_LSB = BYTE_W + BEAT_W;

    // offset inside the block never selects anything: the burst covers it
    logic unused_offset;
    assign unused_offset = ^addr[BLK_LSB-1:0];

    always_comb begin
        row = addr[ROW_LSB +: ROW_W];
        if (line_mode) begin
            bank     = addr[BLK_LSB +: BANK_W];
            col_base = {addr[BLK_LSB+BANK_W +: HI_W], {BEAT_W{1'b0}}};
        end else begin
            bank     = addr[BYTE_W+COL_W +: BANK_W];
            col_base = {addr[BLK_LSB +: HI_W], {BEAT_W{1'b0}}};
        end
    end
endmodule

// File: rtl/rbs_open_rows.sv
module rbs_open_rows #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_open,
    output logic [ROW_W-1:0]  look_row,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  set_row
);
    localparam int BANKS = 1 << BANK_W;

    logic             open_q [BANKS];
    logic [ROW_W-1:0] row_q  [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                open_q[g] <= 1'b0;
                row_q[g]  <= '0;
            end else if (set_en && upd_bank == BANK_W'(g)) begin
                open_q[g] <= 1'b1;
                row_q[g]  <= set_row;
            end else if (clr_en && upd_bank == BANK_W'(g)) begin
                open_q[g] <= 1'b0;
            end
        end
    end

    assign look_open = open_q[look_bank];
    assign look_row  = row_q[look_bank];
endmodule

// File: rtl/rbs_beat_pipe.sv
module rbs_beat_pipe #(
    parameter int DEPTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_v,
    output logic out_v
);
    logic [DEPTH-1:0] sh_q;

    if (DEPTH == 1) begin : g_one
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= in_v;
        end
    end else begin : g_many
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[DEPTH-2:0], in_v};
        end
    end

    assign out_v = sh_q[DEPTH-1];
endmodule

// File: rtl/dram_open_row_seq.sv
module dram_open_row_seq
    import rbs_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3,
    parameter int COL_W  = 11,
    parameter int BYTE_W = 3,
    parameter int BEATS  = 8,
    parameter int TRP    = 4,
    parameter int TRCD   = 4,
    parameter int TCL    = 5,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W + BYTE_W,
    localparam int DATA_W = 8 * (1 << BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_line_mode,
    output logic [CMD_W-1:0]  cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    input  logic [DATA_W-1:0] dq_in,
    output logic              beat_valid,
    output logic [DATA_W-1:0] beat_data,
    output logic              beat_last
);
    localparam int BEAT_W  = $clog2(BEATS);
    localparam int GAP_MAX = (TRP > TRCD) ? TRP : TRCD;
    localparam int CNT_W   = $clog2(GAP_MAX) + 1;
    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

    typedef struct packed {
        sq_state_e         st;
        sq_state_e         after;
        logic [CNT_W-1:0]  cnt;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [BEAT_W-1:0] rd_idx;
        logic [BEAT_W-1:0] beat_idx;
    } seq_t;

    seq_t s_d, s_q;

    logic [BANK_W-1:0] dec_bank;
    logic [ROW_W-1:0]  dec_row;
    logic [COL_W-1:0]  dec_col;
    logic              look_open;
    logic [ROW_W-1:0]  look_row;
    logic              tbl_set, tbl_clr;
    logic              beat_v;

    rbs_addr_map #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W),
        .BYTE_W(BYTE_W), .BEAT_W(BEAT_W), .ADDR_W(ADDR_W)
    ) u_map (
        .addr(req_addr), .line_mode(req_line_mode),
        .bank(dec_bank), .row(dec_row), .col_base(dec_col)
    );

    rbs_open_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .look_bank(dec_bank), .look_open(look_open), .look_row(look_row),
        .set_en(tbl_set), .clr_en(tbl_clr),
        .upd_bank(s_q.bank), .set_row(s_q.row)
    );

    rbs_beat_pipe #(.DEPTH(TCL)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_v(cmd[CMD_READ]), .out_v(beat_v)
    );

    always_comb begin
        s_d     = s_q;
        cmd     = '0;
        tbl_set = 1'b0;
        tbl_clr = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    s_d.bank     = dec_bank;
                    s_d.row      = dec_row;
                    s_d.col      = dec_col;
                    s_d.rd_idx   = '0;
                    s_d.beat_idx = '0;
                    if (!look_open)           s_d.st = SQ_ACT;
                    else if (look_row == dec_row) s_d.st = SQ_READ;
                    else                      s_d.st = SQ_PRE;
                end
            end
            SQ_PRE: begin
                cmd[CMD_PRE] = 1'b1;
                tbl_clr      = 1'b1;
                if (TRP > 1) begin
                    s_d.st    = SQ_GAP;
                    s_d.after = SQ_ACT;
                    s_d.cnt   = CNT_W'(TRP - 2);
                end else begin
                    s_d.st = SQ_ACT;
                end
            end
            SQ_ACT: begin
                cmd[CMD_ACT] = 1'b1;
                tbl_set      = 1'b1;
                if (TRCD > 1) begin
                    s_d.st    = SQ_GAP;
                    s_d.after = SQ_READ;
                    s_d.cnt   = CNT_W'(TRCD - 2);
                end else begin
                    s_d.st = SQ_READ;
                end
            end
            SQ_GAP: begin
                if (s_q.cnt == '0) s_d.st  = s_q.after;
                else               s_d.cnt = s_q.cnt - 1'b1;
            end
            SQ_READ: begin
                cmd[CMD_READ] = 1'b1;
                s_d.rd_idx    = s_q.rd_idx + 1'b1;
                if (s_q.rd_idx == LAST_IDX) s_d.st = SQ_DRAIN;
            end
            SQ_DRAIN: ;
            default: s_d.st = SQ_IDLE;
        endcase

        if (beat_v) begin
            s_d.beat_idx = s_q.beat_idx + 1'b1;
            if (s_q.beat_idx == LAST_IDX) s_d.st = SQ_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready  = (s_q.st == SQ_IDLE);
    assign cmd_bank   = s_q.bank;
    assign cmd_row    = s_q.row;
    assign cmd_col    = s_q.col | COL_W'(s_q.rd_idx);
    assign beat_valid = beat_v;
    assign beat_data  = dq_in;
    assign beat_last  = beat_v && (s_q.beat_idx == LAST_IDX);
endmodule

// File: rtl/rbs_seq_chk.sv
module rbs_seq_chk #(
    parameter int COL_W = 11,
    parameter int BEATS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       cmd,
    input logic [COL_W-1:0] cmd_col,
    input logic             beat_valid,
    input logic             beat_last
);
    localparam int BW = $clog2(BEATS);

    // R10
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd == 3'b000 && !beat_valid));

    // R8
    last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R9
    reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |=> req_ready);

    // R7
    pre_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd[0] |=> !cmd[2]);

    // R7
    burst_next_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd[2] && cmd_col[BW-1:0] != BW'(BEATS - 1))
            |=> (cmd[2] && cmd_col == $past(cmd_col) + 1'b1));

    // R7
    burst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd[2] && cmd_col[BW-1:0] == BW'(BEATS - 1)) |=> !cmd[2]);
endmodule

bind dram_open_row_seq rbs_seq_chk #(.COL_W(COL_W), .BEATS(BEATS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cmd(cmd), .cmd_col(cmd_col), .beat_valid(beat_valid), .beat_last(beat_last)
);

// File: tb/dram_open_row_seq_tb.sv
module dram_open_row_seq_tb;
    localparam int TRP  = 2;
    localparam int TRCD = 1;
    localparam int TCL  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [30:0] req_addr = '0;
    logic        req_line_mode = 1'b0;
    logic [2:0]  cmd;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic [10:0] cmd_col;
    logic [63:0] dq_in;
    logic        beat_valid;
    logic [63:0] beat_data;
    logic        beat_last;

    dram_open_row_seq #(.TRP(TRP), .TRCD(TRCD), .TCL(TCL)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_line_mode(req_line_mode), .cmd(cmd),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .dq_in(dq_in),
        .beat_valid(beat_valid), .beat_data(beat_data), .beat_last(beat_last)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int b, input int r, input int c);
        return {8'(b), 16'(r), 16'(c), 24'hC3A55A};
    endfunction

    function automatic logic [30:0] mk_addr(input bit m, input int row, input int bank,
                                            input int cblk, input int low);
        if (!m) return {14'(row), 3'(bank), 8'(cblk), 6'(low)};
        return {14'(row), 8'(cblk), 3'(bank), 6'(low)};
    endfunction

    function automatic void decode(input logic [30:0] a, input bit m,
                                   output int b, output int r, output int c);
        r = int'(a[30:17]);
        if (!m) begin
            b = int'(a[16:14]);
            c = int'({a[13:6], 3'b000});
        end else begin
            b = int'(a[8:6]);
            c = int'({a[16:9], 3'b000});
        end
    endfunction

    // request-side expectation
    bit r_open [8] = '{default: 1'b0};
    int r_row  [8] = '{default: 0};
    int exp_bank, exp_row, exp_col;
    bit exp_mode;
    int n_pre, n_act, n_rd, n_beat;
    int pre_at, act_at, rd0_at, last_at;

    // device model driven only by the command pins
    bit          m_open [8] = '{default: 1'b0};
    logic [13:0] m_row  [8];
    logic        rd_seen = 1'b0;
    logic [63:0] rd_pat;
    logic [63:0] dq_pipe [TCL];
    int          q_t[$];
    logic [63:0] q_d[$];

    always @(posedge clk) begin
        dq_pipe[0] <= rd_seen ? rd_pat : 64'h0;
        for (int i = 1; i < TCL; i++) dq_pipe[i] <= dq_pipe[i-1];
    end
    assign dq_in = dq_pipe[TCL-1];

    always @(negedge clk) begin
        rd_seen = 1'b0;
        if (rst_n) begin
            if (cmd != 3'b000)
                chk($countones(cmd) == 1, "R10 single command bit", 64'(cmd), 64'h1);
            if (cmd[0]) begin
                chk(m_open[cmd_bank] && cmd_bank == 3'(exp_bank),
                    "R5 precharge hits the target open bank", 64'(cmd_bank), 64'(exp_bank));
                m_open[cmd_bank] = 1'b0;
                pre_at = cyc;
                n_pre++;
            end
            if (cmd[1]) begin
                chk(!m_open[cmd_bank], "R11 activate only reaches a closed bank",
                    64'(m_open[cmd_bank]), 64'h0);
                chk(cmd_bank == 3'(exp_bank) && cmd_row == 14'(exp_row),
                    "R4 activate bank and row", {cmd_bank, cmd_row}, {3'(exp_bank), 14'(exp_row)});
                if (n_pre > 0)
                    chk(cyc - pre_at == TRP, "R7 precharge to activate gap", 64'(cyc - pre_at), 64'(TRP));
                m_open[cmd_bank] = 1'b1;
                m_row[cmd_bank]  = cmd_row;
                act_at = cyc;
                n_act++;
            end
            if (cmd[2]) begin
                chk(m_open[cmd_bank] && m_row[cmd_bank] == cmd_row,
                    "R6 read targets the open row", 64'(cmd_row), 64'(m_row[cmd_bank]));
                chk(cmd_col == 11'(exp_col + n_rd), "R7 read column order",
                    64'(cmd_col), 64'(exp_col + n_rd));
                if (n_rd == 0) begin
                    rd0_at = cyc;
                    if (n_act > 0)
                        chk(cyc - act_at == TRCD, "R7 activate to read gap", 64'(cyc - act_at), 64'(TRCD));
                end else begin
                    chk(cyc == rd0_at + n_rd, "R7 reads back to back", 64'(cyc), 64'(rd0_at + n_rd));
                end
                q_t.push_back(cyc + TCL);
                q_d.push_back(pat(exp_bank, exp_row, exp_col + n_rd));
                rd_seen = 1'b1;
                rd_pat  = pat(int'(cmd_bank), int'(cmd_row), int'(cmd_col));
                n_rd++;
            end
            if (q_t.size() > 0 && q_t[0] == cyc) begin
                chk(beat_valid, "R8 beat valid TCL after read", 64'(beat_valid), 64'h1);
                chk(beat_data == q_d[0], exp_mode ? "R3 line-mode block data" : "R2 row-mode block data",
                    beat_data, q_d[0]);
                chk(beat_last == (n_beat == 7), "R8 last flag on eighth beat",
                    64'(beat_last), 64'(n_beat == 7));
                if (beat_last) last_at = cyc;
                n_beat++;
                void'(q_t.pop_front());
                void'(q_d.pop_front());
            end else if (beat_valid) begin
                chk(1'b0, "R8 beat with no read behind it", 64'h1, 64'h0);
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_req(input bit m, input logic [30:0] a);
        int b, r, c, kind;
        string tag;
        while (!req_ready) tick();
        decode(a, m, b, r, c);
        kind = !r_open[b] ? 1 : ((r_row[b] == r) ? 0 : 2);
        tag  = (kind == 0) ? "R6 hit sequence" : ((kind == 1) ? "R4 closed-bank sequence" : "R5 conflict sequence");
        r_open[b] = 1'b1;
        r_row[b]  = r;
        exp_bank = b; exp_row = r; exp_col = c; exp_mode = m;
        n_pre = 0; n_act = 0; n_rd = 0; n_beat = 0;
        req_valid = 1'b1; req_addr = a; req_line_mode = m;
        tick();
        req_valid = 1'b0;
        chk(!req_ready, "R9 busy after accept", 64'(req_ready), 64'h0);
        while (!req_ready) tick();
        chk(cyc == last_at + 1, "R9 ready right after last beat", 64'(cyc), 64'(last_at + 1));
        chk(n_pre == ((kind == 2) ? 1 : 0), tag, 64'(n_pre), 64'(kind == 2));
        chk(n_act == ((kind != 0) ? 1 : 0), tag, 64'(n_act), 64'(kind != 0));
        chk(n_rd == 8, "R7 eight reads per block", 64'(n_rd), 64'h8);
        chk(n_beat == 8, "R8 eight beats per block", 64'(n_beat), 64'h8);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: request never completed actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        int lcg;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state at the ports
        chk(req_ready, "R1 ready after reset", 64'(req_ready), 64'h1);
        chk(cmd == 3'b000, "R1 no command after reset", 64'(cmd), 64'h0);
        chk(!beat_valid, "R1 no beat after reset", 64'(beat_valid), 64'h0);

        // R1 R4: closed bank, row layout, offset bits ignored (R7 alignment)
        do_req(1'b0, mk_addr(1'b0, 100, 2, 8'h11, 6'h2D));
        // R6: same row, other block
        do_req(1'b0, mk_addr(1'b0, 100, 2, 8'h7F, 6'h00));
        // R5: other row in the same bank
        do_req(1'b0, mk_addr(1'b0, 200, 2, 8'h05, 6'h3F));
        // R3: consecutive blocks spread over banks 0, 1, 2
        for (int i = 0; i < 3; i++) do_req(1'b1, 31'h0004_0000 + 31'(i * 64));
        // R3 hit in line layout
        do_req(1'b1, 31'h0004_0200);
        // R11: interleave two banks, return to the first as a hit
        do_req(1'b0, mk_addr(1'b0, 7, 3, 1, 0));
        do_req(1'b0, mk_addr(1'b0, 9, 4, 2, 0));
        do_req(1'b0, mk_addr(1'b0, 7, 3, 3, 0));

        lcg = 12345;
        for (int k = 0; k < 40; k++) begin
            bit m;
            lcg = lcg * 1103515245 + 12345;
            m = lcg[16];
            do_req(m, mk_addr(m, (lcg >>> 20) & 3, (lcg >>> 8) & 7, (lcg >>> 11) & 255, lcg & 63));
        end
        repeat (2) tick();
        finish_run();
    end
endmodule